// File: doc/BRIEF.md
# ADC configuration register writer

This block sits on the host side of a serial SAR converter and writes its 8-bit setup byte. The host presents an interface-mode code, a shutdown flag and a reference-mode code on parallel inputs and pulses a start request. The block then drives three wires toward the converter: a convert-start strobe, a serial clock and a data line. It opens a load frame by pulling the strobe low while the serial clock sits high, and sends the byte MSB first so the converter captures one bit on each of eight falling clock edges. It closes the frame by raising the strobe again.

The serial clock comes from the system clock through a divider. The divider is sized from two parameters, the system clock frequency and the highest clock rate the converter accepts. Separate parameters, counted in system clocks, set the margins around the strobe edges. Reference-mode codes outside the valid range are replaced by a fixed code and flagged. While a frame is in flight the block reports busy and ignores further requests. It gives a one-cycle done pulse when the strobe returns high.

Top module: `adc_cfg_loader`

## Requirements
- R1: Out of reset and whenever not busy, `cnvst_o`, `sclk_o` and `din_o` are all 1 and `busy_o` and `done_o` are 0.
- R2: The byte sent is {2'b00, mode_i[1:0], shdn_i, 1'b0, ref2}. ref2 is ref_i[1:0] when ref_i is at most 3, otherwise REF_CLAMP. The byte goes out MSB (bit 7) first. Mode codes are 00/01 single device without/with busy indicator and 10/11 chained without/with busy indicator. Shutdown 1 selects static shutdown.
- R3: On an accepted start, `busy_o` rises on the next clock edge. The strobe stays high with SCLK high for SETUP_CYC cycles, then falls while SCLK is still high. SCLK stays high a further HOLD_CYC cycles after the strobe falls.
- R4: While the strobe is low, `din_o` never changes while SCLK stays low. A new bit appears only together with an SCLK rising edge.
- R5: Each frame has exactly 8 SCLK falling edges, all while the strobe is low.
- R6: After the 8th falling edge SCLK stays low for HALF + HOLD_CYC cycles, and then the strobe rises. `done_o` is 1 for exactly the one cycle in which the strobe has just risen and SCLK is still low. SCLK returns high on the next cycle.
- R7: A start request while `busy_o` is 1 has no effect on the frame in progress and does not start a later frame.
- R8: `ref_err_o` takes the value (ref_i > 3) at each accepted start and holds it until the next accepted start.
- R9: SCLK high and low phases inside the frame each last HALF = ceil(SYS_CLK_MHZ / (2*SCLK_MAX_MHZ)) system clocks, so SCLK never exceeds SCLK_MAX_MHZ.
- R10: A frame keeps `busy_o` high for SETUP_CYC + 2*HOLD_CYC + 15*HALF + 1 cycles. A start held high continuously is accepted again one idle cycle after the frame ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to write the configuration byte |
| mode_i | input | 2 | Interface-mode code |
| shdn_i | input | 1 | Static shutdown select |
| ref_i | input | 3 | Reference-mode code, valid 0 to 3 |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| ref_err_o | output | 1 | Last accepted reference code was out of range |
| cnvst_o | output | 1 | Convert-start strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Serial configuration data to the converter |

## Verification
The hardest case to reach from the ports is a request arriving near a frame boundary. One variant lands in the done cycle or in the single idle cycle after it. The other is a request held high across both, which must be accepted exactly once more and one cycle late. The stimulus covers three cases. It raises start in the middle of a frame with different field values. It holds start high over two whole frames. It feeds a clamped reference code followed by a valid one. A per-cycle reference model built from queued wire levels is compared with the pins on every clock, so any drift of one cycle shows up at once.

// File: rtl/adc_cfg_pkg.sv
// Shared types and helpers for the ADC configuration writer.
// Assumes an 8-bit configuration byte whose field positions the converter decodes.
package adc_cfg_pkg;

    localparam int CFG_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ARM,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_END
    } seq_state_e;

    // Packs the fields into the byte: reserved zeros, mode, shutdown, reference.
    function automatic logic [CFG_BITS-1:0] pack_cfg(
        input logic [1:0] mode,
        input logic       shdn,
        input logic [1:0] refm
    );
        return {2'b00, mode, shdn, 1'b0, refm};
    endfunction

endpackage

// File: rtl/adc_cfg_timer.sv
// Phase timer: a load with length L makes 'last' rise on the L-th cycle after it.
// Assumes every length loaded is at least 1.
module adc_cfg_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         last
);

    logic [W-1:0] cnt;

    // Counts down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (load)     cnt <= len - W'(1);
        else if (cnt != 0) cnt <= cnt - W'(1);
    end

    assign last = (cnt == '0);

    p_len_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

endmodule

// File: rtl/adc_cfg_shreg.sv
// Parallel-load shift register: it sends the byte MSB first and fills with ones.
// Assumes load and shift are never asserted together.
module adc_cfg_shreg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] data,
    input  logic         shift,
    output logic         msb
);

    logic [N-1:0] sr;

    // Holds the byte and moves the next bit into the MSB slot on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '1;
        else if (load)  sr <= data;
        else if (shift) sr <= {sr[N-2:0], 1'b1};
    end

    assign msb = sr[N-1];

    p_no_load_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/adc_cfg_seq.sv
// Frame sequencer: it orders the strobe, serial clock and data-enable phases of one load.
// Assumes the timer reports 'last' on the final cycle of each loaded phase.
module adc_cfg_seq
    import adc_cfg_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 2,
    parameter int HALF      = 2,
    parameter int TW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tmr_last,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_len,
    output logic          sh_load,
    output logic          sh_shift,
    output logic          cnvst,
    output logic          sclk,
    output logic          busy,
    output logic          done,
    output logic          din_en
);

    localparam logic [TW-1:0] L_SETUP = TW'(SETUP_CYC);
    localparam logic [TW-1:0] L_HOLD  = TW'(HOLD_CYC);
    localparam logic [TW-1:0] L_HALF  = TW'(HALF);
    localparam logic [2:0]    LAST_BIT = 3'(CFG_BITS - 1);

    seq_state_e state, nxt;
    logic [2:0] bit_idx, idx_nxt;

    // Chooses the next phase and the timer length it needs.
    always_comb begin
        nxt      = state;
        idx_nxt  = bit_idx;
        tmr_load = 1'b0;
        tmr_len  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                nxt = ST_LEAD; tmr_load = 1'b1; tmr_len = L_SETUP; sh_load = 1'b1;
            end
            ST_LEAD: if (tmr_last) begin
                nxt = ST_ARM; tmr_load = 1'b1; tmr_len = L_HOLD;
            end
            ST_ARM: if (tmr_last) begin
                nxt = ST_LOW; tmr_load = 1'b1; tmr_len = L_HALF; idx_nxt = '0;
            end
            ST_LOW: if (tmr_last) begin
                tmr_load = 1'b1;
                if (bit_idx == LAST_BIT) begin
                    nxt = ST_TAIL; tmr_len = L_HOLD;
                end else begin
                    nxt = ST_HIGH; tmr_len = L_HALF; sh_shift = 1'b1;
                end
            end
            ST_HIGH: if (tmr_last) begin
                nxt = ST_LOW; tmr_load = 1'b1; tmr_len = L_HALF; idx_nxt = bit_idx + 3'd1;
            end
            ST_TAIL: if (tmr_last) nxt = ST_END;
            ST_END:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Registers the state and drives the wire levels of the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            cnvst   <= 1'b1;
            sclk    <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b0;
            din_en  <= 1'b0;
        end else begin
            state   <= nxt;
            bit_idx <= idx_nxt;
            cnvst   <= (nxt == ST_IDLE) || (nxt == ST_LEAD) || (nxt == ST_END);
            sclk    <= (nxt == ST_IDLE) || (nxt == ST_LEAD) || (nxt == ST_ARM) || (nxt == ST_HIGH);
            busy    <= (nxt != ST_IDLE);
            done    <= (nxt == ST_END);
            din_en  <= (nxt == ST_ARM) || (nxt == ST_LOW) || (nxt == ST_HIGH) || (nxt == ST_TAIL);
        end
    end

    p_open_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnvst) |-> sclk);

    p_fall_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> !cnvst);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && sclk));

    p_done_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(cnvst) && !sclk));

    p_start_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |-> !sh_load);

endmodule

// File: rtl/adc_cfg_loader.sv
// Top of the ADC configuration writer: it builds the byte, clamps bad reference
// codes and wires sequencer, timer and shifter to the three converter lines.
// Assumes SYS_CLK_MHZ and SCLK_MAX_MHZ are positive and the margins are at least 1.
module adc_cfg_loader
    import adc_cfg_pkg::*;
#(
    parameter int         SYS_CLK_MHZ  = 200,
    parameter int         SCLK_MAX_MHZ = 50,
    parameter int         SETUP_CYC    = 2,
    parameter int         HOLD_CYC     = 2,
    parameter logic [1:0] REF_CLAMP    = 2'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic       shdn_i,
    input  logic [2:0] ref_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       ref_err_o,
    output logic       cnvst_o,
    output logic       sclk_o,
    output logic       din_o
);

    localparam int HALF_RAW = (SYS_CLK_MHZ + 2 * SCLK_MAX_MHZ - 1) / (2 * SCLK_MAX_MHZ);
    localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
    localparam int MAX_LEN  = (HALF > SETUP_CYC) ? ((HALF > HOLD_CYC) ? HALF : HOLD_CYC)
                                                 : ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
    localparam int TW       = $clog2(MAX_LEN + 1);

    logic          tmr_load, tmr_last, sh_load, sh_shift, sh_msb, din_en;
    logic [TW-1:0] tmr_len;
    logic [1:0]    ref_use;
    logic          ref_bad;
    logic [CFG_BITS-1:0] cfg_byte;

    assign ref_bad  = ref_i[2];
    assign ref_use  = ref_bad ? REF_CLAMP : ref_i[1:0];
    assign cfg_byte = pack_cfg(mode_i, shdn_i, ref_use);

    adc_cfg_seq #(
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .HALF      (HALF),
        .TW        (TW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .tmr_last (tmr_last),
        .tmr_load (tmr_load),
        .tmr_len  (tmr_len),
        .sh_load  (sh_load),
        .sh_shift (sh_shift),
        .cnvst    (cnvst_o),
        .sclk     (sclk_o),
        .busy     (busy_o),
        .done     (done_o),
        .din_en   (din_en)
    );

    adc_cfg_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    adc_cfg_shreg #(.N(CFG_BITS)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .data  (cfg_byte),
        .shift (sh_shift),
        .msb   (sh_msb)
    );

    // Records at each accepted request whether the reference code had to be clamped.
    always_ff @(posedge clk) begin
        if (!rst_n)       ref_err_o <= 1'b0;
        else if (sh_load) ref_err_o <= ref_bad;
    end

    assign din_o = din_en ? sh_msb : 1'b1;

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cnvst_o && sclk_o && din_o && !done_o));

    p_din_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_o && !cnvst_o && $past(!sclk_o) && $past(!cnvst_o)) |-> $stable(din_o));

    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ref_err_o));

endmodule

// File: tb/adc_cfg_loader_bench.sv
// Bench: a queue-based per-cycle model of the expected wire levels, compared on every clock.
module adc_cfg_loader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SYS_MHZ    = 200;
    localparam int MAX_MHZ    = 50;
    localparam int SETUP      = 2;
    localparam int HOLD       = 2;
    localparam int HALF       = 2;  // ceil(200 / (2*50))
    localparam logic [1:0] CLAMP = 2'd0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic shdn_i = 1'b0;
    logic [2:0] ref_i = 3'd0;
    logic busy_o, done_o, ref_err_o, cnvst_o, sclk_o, din_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_cfg_loader #(
        .SYS_CLK_MHZ  (SYS_MHZ),
        .SCLK_MAX_MHZ (MAX_MHZ),
        .SETUP_CYC    (SETUP),
        .HOLD_CYC     (HOLD),
        .REF_CLAMP    (CLAMP)
    ) u_adc_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .shdn_i(shdn_i),
        .ref_i(ref_i), .busy_o(busy_o), .done_o(done_o), .ref_err_o(ref_err_o),
        .cnvst_o(cnvst_o), .sclk_o(sclk_o), .din_o(din_o)
    );

    typedef struct packed { logic cv; logic sk; logic dt; logic bz; logic dn; } lvl_t;
    localparam lvl_t IDLE_LVL = '{cv:1'b1, sk:1'b1, dt:1'b1, bz:1'b0, dn:1'b0};

    lvl_t q[$];
    lvl_t exp_l = IDLE_LVL;
    logic exp_err = 1'b0;
    int total = 0, bad = 0, frames_exp = 0, frames_seen = 0, cycles = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic push_n(input int n, input lvl_t l);
        for (int k = 0; k < n; k++) q.push_back(l);
    endtask

    // Builds the whole expected frame from the field values (R2, R3, R6, R9, R10).
    task automatic build_frame(input logic [1:0] m, input logic s, input logic [2:0] r);
        logic [7:0] b;
        logic [1:0] rr;
        rr = (r > 3'd3) ? CLAMP : r[1:0];
        b = {2'b00, m, s, 1'b0, rr};
        push_n(SETUP, '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0});
        push_n(HOLD,  '{1'b0, 1'b1, b[7], 1'b1, 1'b0});
        for (int i = 0; i < 8; i++) begin
            push_n(HALF, '{1'b0, 1'b0, b[7-i], 1'b1, 1'b0});
            if (i < 7) push_n(HALF, '{1'b0, 1'b1, b[6-i], 1'b1, 1'b0});
        end
        push_n(HOLD, '{1'b0, 1'b0, b[0], 1'b1, 1'b0});
        q.push_back('{1'b1, 1'b0, 1'b1, 1'b1, 1'b1});
        q.push_back(IDLE_LVL);
        exp_err = (r > 3'd3);
        frames_exp++;
    endtask

    // Reference model: advances one expected cycle per clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            exp_l   = IDLE_LVL;
            exp_err = 1'b0;
        end else if (q.size() > 0) begin
            exp_l = q.pop_front();
        end else if (start_i) begin
            build_frame(mode_i, shdn_i, ref_i);
            exp_l = q.pop_front();
        end else begin
            exp_l = IDLE_LVL;
        end
    end

    logic p_sk = 1'b1, p_cv = 1'b1, p_dt = 1'b1;
    int falls = 0;

    // Compares all pins against the model and tracks per-frame edge counts.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(cnvst_o === exp_l.cv, "R3 cnvst", cnvst_o, exp_l.cv);
            chk(sclk_o  === exp_l.sk, "R9 sclk",  sclk_o,  exp_l.sk);
            chk(din_o   === exp_l.dt, "R2 din",   din_o,   exp_l.dt);
            chk(busy_o  === exp_l.bz, "R10 busy", busy_o,  exp_l.bz);
            chk(done_o  === exp_l.dn, "R6 done",  done_o,  exp_l.dn);
            chk(ref_err_o === exp_err, "R8 ref_err", ref_err_o, exp_err);
            if (!cnvst_o && !p_cv && !sclk_o && !p_sk)
                chk(din_o === p_dt, "R4 din moved while sclk low", din_o, p_dt);
            if (p_sk && !sclk_o) begin
                chk(!cnvst_o, "R5 sclk fell outside frame", cnvst_o, 0);
                falls++;
            end
            if (!p_cv && cnvst_o) begin
                chk(falls == 8, "R5 falling edges per frame", falls, 8);
                falls = 0;
                frames_seen++;
            end
        end
        p_sk = sclk_o; p_cv = cnvst_o; p_dt = din_o;
        if (cycles > 20000 && !finished) begin
            chk(0, "watchdog", cycles, 20000);
            finish_run();
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic request(input logic [1:0] m, input logic s, input logic [2:0] r);
        @(negedge clk);
        mode_i = m; shdn_i = s; ref_i = r; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset levels
        chk(cnvst_o === 1'b1 && sclk_o === 1'b1 && din_o === 1'b1, "R1 reset lines", {cnvst_o, sclk_o, din_o}, 7);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1 reset status", {busy_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        request(2'b01, 1'b0, 3'd3); wait_idle();   // R2 mixed bits
        request(2'b10, 1'b1, 3'd0); wait_idle();   // R2 shutdown set
        request(2'b11, 1'b1, 3'd5); wait_idle();   // R8 clamp and flag
        chk(ref_err_o === 1'b1, "R8 flag after bad code", ref_err_o, 1);
        request(2'b00, 1'b0, 3'd2); wait_idle();   // R8 flag cleared
        chk(ref_err_o === 1'b0, "R8 flag after good code", ref_err_o, 0);

        // R7: request in the middle of a frame with other fields is ignored
        request(2'b01, 1'b1, 3'd1);
        repeat (10) @(negedge clk);
        mode_i = 2'b10; shdn_i = 1'b0; ref_i = 3'd7; start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        start_i = 1'b1;                            // R7: request during the done cycle
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        chk(ref_err_o === 1'b0, "R7 ignored request left flag", ref_err_o, 0);

        // R10: start held high over two frames
        mode_i = 2'b11; shdn_i = 1'b0; ref_i = 3'd1; start_i = 1'b1;
        repeat (2 * (SETUP + 2*HOLD + 15*HALF + 2)) @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        chk(frames_seen == frames_exp, "R7 frame count", frames_seen, frames_exp);
        chk(frames_exp == 7, "R10 frames issued", frames_exp, 7);
        finish_run();
    end

endmodule